// File: doc/BRIEF.md
# Feedback Automatic Gain Limiter

This block limits the level of one audio band by scaling each incoming sample with a gain held in a register and adjusting that gain from the level of its own scaled output. Feedback sets the compression ratio: no register programs it. The magnitude of every output sample goes into a first-order softening filter. The filter has two coefficients, a new-sample weight and a history weight, and the two should sum to unity. The smoothed level is compared with a programmable linear threshold. While the level is above the threshold, the gain moves down by an attack step on each accepted sample. Otherwise it climbs back toward unity by a release step.

The attack step is not programmed on its own. It is twice the sum of the attack value and the release step, so the gain always falls faster than it recovers. Each band of a multi-band design uses its own instance, with its own threshold, coefficients and step registers. Samples are signed two's complement of DATA_W bits. Gain, coefficients and level are unsigned values with DATA_W-1 fraction bits, so unity is 2^(DATA_W-1).

Top module: `fb_gain_limiter`

## Requirements
- R1: After a synchronous active-low reset, gain_out is unity (0x800000 at default width), out_valid is 0, out_sample is 0 and the smoothed level is zero.
- R2: One cycle after a clock edge with in_valid high, out_valid is high and out_sample equals floor(in_sample × gain / 2^23), using the gain from before that edge. out_valid is low one cycle after an edge with in_valid low.
- R3: On an accepted sample whose smoothed level is not above the threshold, the gain rises by rel_step, saturating at unity.
- R4: On an accepted sample whose smoothed level is above the threshold, the gain falls by 2 × (atk_val + rel_step), saturating at zero.
- R5: One cycle after each output sample y, the level becomes floor((alpha × |y| + omega × level) / 2^23), saturating at 2^24−1.
- R6: While in_valid is low, gain_out and out_sample hold their values whatever in_sample carries.
- R7: With alpha at unity and omega at zero, the level equals the magnitude of the most recent output sample, with no softening.
- R8: A level exactly equal to the threshold counts as not above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DATA_W | Signed input sample |
| thr_lvl | input | DATA_W | Linear threshold, same scale as the level |
| soft_alpha | input | DATA_W | Softening weight on the new magnitude, 1.23 |
| soft_omega | input | DATA_W | Softening weight on the prior level, 1.23 |
| atk_val | input | DATA_W | Attack value that feeds the attack step |
| rel_step | input | DATA_W | Release step per sample |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | DATA_W | Gain-scaled signed output |
| gain_out | output | DATA_W | Current gain, 1.23 |

## Verification
A table of samples runs first. It mixes large positive and large negative inputs with thresholds well above and well below the smoothed level. This separates the release path from the attack path, and a sign or magnitude error in the level detector shows up as a wrong gain decision on a later sample. Directed cases then drive the gain to zero with a huge attack value and to unity with a huge release step, so both clamps are exercised. A no-softening run sets the threshold to exactly the last output magnitude, then one below it, which separates a strict comparison from a non-strict one. Idle cycles with changing input data confirm that nothing moves without a strobe.

// File: rtl/lim_pkg.sv
// Package: shared helpers for the feedback gain limiter.
// Assumes fixed-point values with one integer bit and the rest fraction.
package lim_pkg;

    // Decision the gain stepper takes on an accepted sample
    typedef enum logic [1:0] {
        GSTEP_HOLD    = 2'd0,
        GSTEP_ATTACK  = 2'd1,
        GSTEP_RELEASE = 2'd2
    } gstep_e;

endpackage

// File: rtl/lim_scaler.sv
// Module: lim_scaler
// Multiplies each accepted signed sample by the unsigned gain, keeps the
// floor of the product scaled by 2^-FRAC_W, and registers it with a strobe.
// Assumes gain never exceeds unity, so the result always fits DATA_W bits.
module lim_scaler #(
    parameter int DATA_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic        [DATA_W-1:0] gain,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);
    localparam int FRAC_W = DATA_W - 1;
    localparam int PROD_W = 2 * DATA_W + 1;

    logic signed [PROD_W-1:0] prod;

    // Full-precision signed product of sample and zero-extended gain
    always_comb begin
        prod = PROD_W'(in_sample) * PROD_W'($signed({1'b0, gain}));
    end

    // Register the scaled sample and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sample <= prod[FRAC_W+DATA_W-1:FRAC_W];
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));
endmodule

// File: rtl/lim_level_smoother.sv
// Module: lim_level_smoother
// First-order softening filter on the magnitude of the limiter output:
// level = (alpha*|y| + omega*level) >> FRAC_W, saturated to DATA_W bits.
// Assumes alpha + omega is unity; other sums are saturated, not flagged.
module lim_level_smoother #(
    parameter int DATA_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     y_valid,
    input  logic signed [DATA_W-1:0] y_sample,
    input  logic        [DATA_W-1:0] alpha,
    input  logic        [DATA_W-1:0] omega,
    output logic        [DATA_W-1:0] level
);
    localparam int FRAC_W = DATA_W - 1;
    localparam int ACC_W  = 2 * DATA_W + 1;
    localparam int NXT_W  = ACC_W - FRAC_W;

    logic [DATA_W-1:0] mag;
    logic [ACC_W-1:0]  acc;
    logic [NXT_W-1:0]  nxt;
    logic [DATA_W-1:0] nxt_sat;

    // Magnitude of the output sample; the most negative code maps to 2^FRAC_W
    always_comb begin
        mag = y_sample[DATA_W-1] ? DATA_W'(-y_sample) : DATA_W'(y_sample);
    end

    // Weighted sum of new magnitude and prior level, then rescale and clamp
    always_comb begin
        acc = ACC_W'(alpha) * ACC_W'(mag) + ACC_W'(omega) * ACC_W'(level);
        nxt = acc[ACC_W-1:FRAC_W];
        if (|nxt[NXT_W-1:DATA_W]) begin
            nxt_sat = '1;
        end else begin
            nxt_sat = nxt[DATA_W-1:0];
        end
    end

    // Level register, updated once per output sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (y_valid) begin
            level <= nxt_sat;
        end
    end

    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !y_valid |=> $stable(level));
endmodule

// File: rtl/lim_gain_stepper.sv
// Module: lim_gain_stepper
// Holds the limiter gain. On each accepted sample it steps down by
// 2*(attack+release) when the level is strictly above the threshold,
// otherwise up by the release step; the result is clamped to [0, unity].
// Assumes the level and threshold share one linear scale.
module lim_gain_stepper #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] level,
    input  logic [DATA_W-1:0] thr,
    input  logic [DATA_W-1:0] atk_val,
    input  logic [DATA_W-1:0] rel_step,
    output logic [DATA_W-1:0] gain
);
    import lim_pkg::*;

    localparam int FRAC_W = DATA_W - 1;
    localparam int EXT_W  = DATA_W + 3;
    localparam logic [EXT_W-1:0] UNITY = EXT_W'(1) << FRAC_W;

    gstep_e            decision;
    logic [EXT_W-1:0]  gain_ext;
    logic [EXT_W-1:0]  attack_step;
    logic [EXT_W-1:0]  raised;
    logic [DATA_W-1:0] gain_nxt;

    // Choose the step direction for this sample
    always_comb begin
        if (!in_valid) begin
            decision = GSTEP_HOLD;
        end else if (level > thr) begin
            decision = GSTEP_ATTACK;
        end else begin
            decision = GSTEP_RELEASE;
        end
    end

    // Compute the stepped gain with both clamps
    always_comb begin
        gain_ext    = EXT_W'(gain);
        attack_step = (EXT_W'(atk_val) + EXT_W'(rel_step)) << 1;
        raised      = gain_ext + EXT_W'(rel_step);
        gain_nxt    = gain;
        case (decision)
            GSTEP_ATTACK: begin
                if (attack_step >= gain_ext) begin
                    gain_nxt = '0;
                end else begin
                    gain_nxt = DATA_W'(gain_ext - attack_step);
                end
            end
            GSTEP_RELEASE: begin
                if (raised >= UNITY) begin
                    gain_nxt = DATA_W'(UNITY);
                end else begin
                    gain_nxt = DATA_W'(raised);
                end
            end
            default: gain_nxt = gain;
        endcase
    end

    // Gain register, unity after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain <= DATA_W'(UNITY);
        end else begin
            gain <= gain_nxt;
        end
    end

    // R3
    gain_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        EXT_W'(gain) <= UNITY);
    // R4
    attack_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (level > thr)) |=> (gain <= $past(gain)));
    // R3
    release_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(level > thr)) |=> (gain >= $past(gain)));
    // R6
    gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(gain));
endmodule

// File: rtl/fb_gain_limiter.sv
// Module: fb_gain_limiter
// One band of a feedback gain limiter: scales samples by a gain register,
// measures the scaled output through a softening filter and steps the
// gain against a threshold. Assumes one sample per strobe and strobes at
// least two cycles apart for the level to include the previous output.
module fb_gain_limiter #(
    parameter int DATA_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic        [DATA_W-1:0] thr_lvl,
    input  logic        [DATA_W-1:0] soft_alpha,
    input  logic        [DATA_W-1:0] soft_omega,
    input  logic        [DATA_W-1:0] atk_val,
    input  logic        [DATA_W-1:0] rel_step,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample,
    output logic        [DATA_W-1:0] gain_out
);
    logic [DATA_W-1:0] level;

    lim_scaler #(.DATA_W(DATA_W)) u_scaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .gain      (gain_out),
        .out_valid (out_valid),
        .out_sample(out_sample)
    );

    lim_level_smoother #(.DATA_W(DATA_W)) u_smoother (
        .clk     (clk),
        .rst_n   (rst_n),
        .y_valid (out_valid),
        .y_sample(out_sample),
        .alpha   (soft_alpha),
        .omega   (soft_omega),
        .level   (level)
    );

    lim_gain_stepper #(.DATA_W(DATA_W)) u_stepper (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .level   (level),
        .thr     (thr_lvl),
        .atk_val (atk_val),
        .rel_step(rel_step),
        .gain    (gain_out)
    );
endmodule

// File: tb/fb_gain_limiter_bench.sv
module fb_gain_limiter_bench;
    localparam int  W     = 24;
    localparam longint UNITY = 64'sd8388608;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_sample = '0;
    logic        [W-1:0] thr_lvl = '0;
    logic        [W-1:0] soft_alpha = '0;
    logic        [W-1:0] soft_omega = '0;
    logic        [W-1:0] atk_val = '0;
    logic        [W-1:0] rel_step = '0;
    logic                out_valid;
    logic signed [W-1:0] out_sample;
    logic        [W-1:0] gain_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state
    longint m_gain = UNITY;
    longint m_lvl  = 0;

    always #4 clk = ~clk;

    fb_gain_limiter #(.DATA_W(W)) u_fb_gain_limiter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .thr_lvl(thr_lvl), .soft_alpha(soft_alpha), .soft_omega(soft_omega),
        .atk_val(atk_val), .rel_step(rel_step), .out_valid(out_valid),
        .out_sample(out_sample), .gain_out(gain_out)
    );

    // stimulus table: {sample, threshold}
    localparam int NV = 10;
    localparam logic [47:0] VEC [NV] = '{
        {24'h700000, 24'h7FFFFF},
        {24'h900000, 24'h7FFFFF},
        {24'h600000, 24'h100000},
        {24'h7FFFFF, 24'h100000},
        {24'h800000, 24'h100000},
        {24'h000100, 24'h100000},
        {24'h123456, 24'h7FFFFF},
        {24'hFFFFFF, 24'h000000},
        {24'h400000, 24'h200000},
        {24'hC00000, 24'h7FFFFF}
    };

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one sample through the block with the model run alongside
    task automatic run_sample(input logic signed [W-1:0] x);
        longint y, mag, step, nl;
        @(negedge clk);
        in_sample = x;
        in_valid  = 1'b1;
        y = (longint'(x) * m_gain) >>> 23;
        step = 2 * (longint'(atk_val) + longint'(rel_step));
        if (m_lvl > longint'(thr_lvl)) begin
            m_gain = (step >= m_gain) ? 0 : m_gain - step;
        end else begin
            m_gain = m_gain + longint'(rel_step);
            if (m_gain > UNITY) m_gain = UNITY;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid", longint'(out_valid), 1);
        check("R2 sample", longint'(out_sample), y);
        check("R3/R4/R5 gain", longint'(gain_out), m_gain);
        mag = (y < 0) ? -y : y;
        nl = (longint'(soft_alpha) * mag + longint'(soft_omega) * m_lvl) >>> 23;
        if (nl > 64'sd16777215) nl = 64'sd16777215;
        m_lvl = nl;
        @(negedge clk);
        check("R2 idle", longint'(out_valid), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_gain = UNITY;
        m_lvl  = 0;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic signed [W-1:0] held;
        logic        [W-1:0] g_held;
        longint last_mag;
        soft_alpha = 24'h400000;
        soft_omega = 24'h400000;
        atk_val    = 24'h001000;
        rel_step   = 24'h000800;
        do_reset();
        // R1 reset state
        check("R1 gain", longint'(gain_out), UNITY);
        check("R1 valid", longint'(out_valid), 0);
        check("R1 sample", longint'(out_sample), 0);

        // table walk: R2..R5
        for (int i = 0; i < NV; i++) begin
            thr_lvl = VEC[i][23:0];
            run_sample(VEC[i][47:24]);
        end

        // R6: idle cycles with changing data
        held = out_sample;
        g_held = gain_out;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_sample = W'(i * 24'h111111);
        end
        check("R6 sample hold", longint'(out_sample), longint'(held));
        check("R6 gain hold", longint'(gain_out), longint'(g_held));

        // R4 floor at zero
        thr_lvl = 24'h000000;
        atk_val = 24'h7FFFFF;
        run_sample(24'h400000);
        run_sample(24'h400000);
        check("R4 floor", longint'(gain_out), 0);
        run_sample(24'h7FFFFF);
        check("R2 zero gain", longint'(out_sample), 0);

        // R3 clamp at unity
        do_reset();
        thr_lvl  = 24'hFFFFFF;
        atk_val  = 24'h000100;
        rel_step = 24'h7FFFFF;
        run_sample(24'h200000);
        check("R3 unity", longint'(gain_out), UNITY);

        // R7/R8: no softening, threshold at and below last magnitude
        do_reset();
        soft_alpha = 24'h800000;
        soft_omega = 24'h000000;
        rel_step   = 24'h000400;
        atk_val    = 24'h000200;
        thr_lvl    = 24'hFFFFFF;
        run_sample(-24'sd3000000);
        last_mag = 3000000;
        thr_lvl = W'(last_mag);
        run_sample(24'h100000);
        check("R8 equal not over", longint'(gain_out), UNITY);
        last_mag = 64'sd1048576;
        thr_lvl = W'(last_mag - 1);
        run_sample(24'h100000);
        check("R7 over by one", longint'(gain_out), UNITY - 2 * (512 + 1024));

        // R1 reset mid-run
        do_reset();
        check("R1 gain after rerun", longint'(gain_out), UNITY);
        check("R1 valid after rerun", longint'(out_valid), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule